// File: doc/BRIEF.md
# Rectangular Chained-Descriptor DMA Channel

This block is a single DMA channel that copies rectangular blocks of 32-bit words between two regions of on-chip memory. Software places a list of four-word descriptors in memory, programs the byte address of the first one into a head register, and writes the start bit of the command/status register. The channel then reads each descriptor, copies its rows and moves on to the next descriptor until it finishes one whose final-node tag is set. At that point it raises the end flag and returns to idle.

A descriptor gives a source base, a destination base, a row width in bytes, a total byte count, and separate source and destination strides. Within a row, words are copied from consecutive addresses. After each full row, both row bases move forward by their own strides. The descriptor ends when the total byte count has been copied. The size-type and page-option fields are read but have no effect. Writing the reset bit aborts the channel at once.

The register side is a two-register write/read bus. The memory side is a single word-wide port that performs one access per cycle and returns read data one cycle after the request.

Top module: `rect_chain_dma`

## Requirements
- R1: After reset, both registers read as zero and the memory port issues no request.
- R2: A write with `bus_sel`=0 stores bits 31..2 of the descriptor head address. A read with `bus_sel`=0 returns that value with bits 1..0 reading zero.
- R3: A write with `bus_sel`=1 and bit 0 set, made while the channel is idle, starts a chain at the head address. Command/status bit 0 reads 1 while the channel is busy. A start written while the channel is busy has no effect.
- R4: Descriptor layout is as follows. Word 0 (offset 0) is the source byte address. Word 1 (offset 4) is the destination byte address. Word 2 (offset 8) holds the source stride in bits 29..16 and the destination stride in bits 13..0; its bits 31..30 (size type) and 15..14 (page option) have no effect on the copy. Word 3 (offset 12) holds the final-node tag in bit 31, the row width in bytes in bits 30..16, and the total byte count in bits 15..0.
- R5: Within a row, word k is read from the source row base + 4k and written to the destination row base + 4k. After each row-width bytes, both row bases advance by their own strides. A row width of zero acts as 32768 bytes.
- R6: A descriptor copies exactly the total byte count and then stops. A total of zero copies nothing. Bits 1..0 of the addresses, strides, width and total are ignored.
- R7: A descriptor whose final-node tag is 0 is followed by the next descriptor at its own address + 16. The chain ends after the first descriptor whose tag is 1.
- R8: Command/status bit 2 (end) is set when the final descriptor completes and is cleared by a start.
- R9: Command/status bits 31..16 count the bytes copied since the last start. Bits 15..8 count the descriptors completed since the last start.
- R10: A write with `bus_sel`=1 and bit 1 set returns the channel to idle at that clock edge. It clears the end flag and both counters, and no memory access follows it. If that write also has bit 0 set, the reset wins and nothing starts.
- R11: The memory port performs word-aligned accesses. Every memory write is made in the cycle directly after the read that supplied its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 head address, 1 command/status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The channel has two functions that can meet in one cycle.

The first meeting is a software reset arriving while the copy loop is writing a word to memory. The bench provokes this by writing the reset bit a fixed number of cycles into a long transfer. At the very next sample point it expects the status to read all zero, and it then watches the memory port stay silent for a window of cycles.

The second meeting is start and reset written in the same bus write. The bench expects the channel to stay idle, and it checks that it can still run a complete chain afterwards.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the rectangular chained-descriptor DMA.
// Field widths follow the descriptor layout; word-unit widths are derived.
package rcd_pkg;
    localparam int DATA_W    = 32;
    localparam int WADDR_W   = DATA_W - 2;   // word address width
    localparam int STRIDE_W  = 14;           // byte stride field width
    localparam int WIDTH_W   = 15;           // byte row-width field width
    localparam int TOTAL_W   = 16;           // byte total field width
    localparam int NODE_W    = 8;            // completed-descriptor counter
    localparam int STRIDE_WW = STRIDE_W - 2; // stride in words
    localparam int WIDTH_WW  = WIDTH_W - 2;  // row width in words
    localparam int TOTAL_WW  = TOTAL_W - 2;  // total in words

    localparam int CMD_START = 0;
    localparam int CMD_RESET = 1;
    localparam int CMD_END   = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_DREQ, S_DCAP, S_CHK, S_RREQ, S_WRITE, S_NEXT
    } seq_state_t;
endpackage

// File: rtl/rcd_regs.sv
`timescale 1ns/1ps
// Register block: head address, command decode, end flag and progress
// counters. Assumes the sequencer pulses word_done once per copied word and
// node_done once per finished descriptor.
module rcd_regs
    import rcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_sel,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 busy,
    input  logic                 word_done,
    input  logic                 node_done,
    input  logic                 chain_done,
    output logic [WADDR_W-1:0]   head_word,
    output logic                 start_pulse,
    output logic                 abort_pulse
);
    localparam int PAD_W = DATA_W - TOTAL_W - NODE_W - 3;

    logic [WADDR_W-1:0] head_q;
    logic               end_q;
    logic [TOTAL_W-1:0] bytes_q;
    logic [NODE_W-1:0]  nodes_q;
    logic               cmd_wr;

    // Decode command writes; reset beats start, start is dropped while busy.
    always_comb begin
        cmd_wr      = bus_wr && bus_sel;
        abort_pulse = cmd_wr && bus_wdata[CMD_RESET];
        start_pulse = cmd_wr && bus_wdata[CMD_START] && !bus_wdata[CMD_RESET] && !busy;
    end

    // Head address register, low two bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_q <= '0;
        else if (bus_wr && !bus_sel)
            head_q <= bus_wdata[DATA_W-1:2];
    end

    // End flag and progress counters.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_pulse || start_pulse) begin
            end_q   <= 1'b0;
            bytes_q <= '0;
            nodes_q <= '0;
        end else begin
            if (word_done)  bytes_q <= bytes_q + TOTAL_W'(4);
            if (node_done)  nodes_q <= nodes_q + NODE_W'(1);
            if (chain_done) end_q   <= 1'b1;
        end
    end

    // Read mux of the two registers.
    always_comb begin
        if (bus_sel)
            bus_rdata = {bytes_q, nodes_q, {PAD_W{1'b0}}, end_q, 1'b0, busy};
        else
            bus_rdata = {head_q, 2'b00};
    end

    assign head_word = head_q;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !end_q && bytes_q == '0 && nodes_q == '0); // R8
    AST_BYTES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_pulse || abort_pulse) && bytes_q != $past(bytes_q))
        |-> bytes_q == $past(bytes_q) + TOTAL_W'(4)); // R9
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !end_q && bytes_q == '0 && nodes_q == '0); // R10
endmodule

// File: rtl/rcd_walk.sv
`timescale 1ns/1ps
// Rectangle walker: holds the row bases, column and remaining word count of
// one descriptor and produces the current source/destination word address.
// Assumes step is only asserted while words remain.
module rcd_walk
    import rcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [WADDR_W-1:0]   src_base,
    input  logic [WADDR_W-1:0]   dst_base,
    input  logic [STRIDE_WW-1:0] src_stride,
    input  logic [STRIDE_WW-1:0] dst_stride,
    input  logic [WIDTH_WW-1:0]  row_width,
    input  logic [TOTAL_WW-1:0]  total,
    output logic [WADDR_W-1:0]   src_word,
    output logic [WADDR_W-1:0]   dst_word,
    output logic                 last_word,
    output logic                 empty
);
    logic [WADDR_W-1:0]   src_row_q, dst_row_q;
    logic [STRIDE_WW-1:0] sstr_q, dstr_q;
    logic [WIDTH_WW-1:0]  width_q, col_q, col_nx;
    logic [TOTAL_WW-1:0]  remain_q;

    assign col_nx = col_q + WIDTH_WW'(1);

    // Load a descriptor, or step one word with row wrap and stride advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_row_q <= '0;
            dst_row_q <= '0;
            sstr_q    <= '0;
            dstr_q    <= '0;
            width_q   <= '0;
            col_q     <= '0;
            remain_q  <= '0;
        end else if (load) begin
            src_row_q <= src_base;
            dst_row_q <= dst_base;
            sstr_q    <= src_stride;
            dstr_q    <= dst_stride;
            width_q   <= row_width;
            col_q     <= '0;
            remain_q  <= total;
        end else if (step) begin
            remain_q <= remain_q - TOTAL_WW'(1);
            if (col_nx == width_q) begin
                col_q     <= '0;
                src_row_q <= src_row_q + WADDR_W'(sstr_q);
                dst_row_q <= dst_row_q + WADDR_W'(dstr_q);
            end else begin
                col_q <= col_nx;
            end
        end
    end

    // Current addresses and end-of-descriptor flags.
    always_comb begin
        src_word  = src_row_q + WADDR_W'(col_q);
        dst_word  = dst_row_q + WADDR_W'(col_q);
        last_word = (remain_q == TOTAL_WW'(1));
        empty     = (remain_q == '0);
    end

    AST_NO_STEP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !empty); // R6
endmodule

// File: rtl/rcd_seq.sv
`timescale 1ns/1ps
// Channel sequencer: fetches descriptors word by word, runs the read/write
// copy loop and follows the chain. Assumes read data arrives one cycle
// after a read request and that the memory accepts every request.
module rcd_seq
    import rcd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_pulse,
    input  logic                 abort_pulse,
    input  logic [WADDR_W-1:0]   head_word,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic [WADDR_W-1:0]   src_word,
    input  logic [WADDR_W-1:0]   dst_word,
    input  logic                 last_word,
    input  logic                 empty,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 walk_load,
    output logic                 walk_step,
    output logic [WADDR_W-1:0]   src_base,
    output logic [WADDR_W-1:0]   dst_base,
    output logic [STRIDE_WW-1:0] src_stride,
    output logic [STRIDE_WW-1:0] dst_stride,
    output logic [WIDTH_WW-1:0]  row_width,
    output logic [TOTAL_WW-1:0]  total,
    output logic                 word_done,
    output logic                 node_done,
    output logic                 chain_done
);
    seq_state_t           state_q;
    logic [WADDR_W-1:0]   daddr_q;
    logic [1:0]           idx_q;
    logic                 tag_q;

    // State register, descriptor pointer and captured descriptor fields.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_pulse) begin
            state_q    <= S_IDLE;
            daddr_q    <= '0;
            idx_q      <= '0;
            tag_q      <= 1'b0;
            src_base   <= '0;
            dst_base   <= '0;
            src_stride <= '0;
            dst_stride <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start_pulse) begin
                    daddr_q <= head_word;
                    idx_q   <= '0;
                    state_q <= S_DREQ;
                end
                S_DREQ: state_q <= S_DCAP;
                S_DCAP: begin
                    case (idx_q)
                        2'd0: src_base <= mem_rdata[DATA_W-1:2];
                        2'd1: dst_base <= mem_rdata[DATA_W-1:2];
                        2'd2: begin
                            src_stride <= mem_rdata[16+STRIDE_W-1:18];
                            dst_stride <= mem_rdata[STRIDE_W-1:2];
                        end
                        default: tag_q <= mem_rdata[DATA_W-1];
                    endcase
                    idx_q   <= idx_q + 2'd1;
                    state_q <= (idx_q == 2'd3) ? S_CHK : S_DREQ;
                end
                S_CHK:   state_q <= empty ? S_NEXT : S_RREQ;
                S_RREQ:  state_q <= S_WRITE;
                S_WRITE: state_q <= last_word ? S_NEXT : S_RREQ;
                S_NEXT: begin
                    if (tag_q) begin
                        state_q <= S_IDLE;
                    end else begin
                        daddr_q <= daddr_q + WADDR_W'(4);
                        idx_q   <= '0;
                        state_q <= S_DREQ;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Memory port drive and pulses to the walker and register block.
    always_comb begin
        busy       = (state_q != S_IDLE);
        mem_req    = (state_q == S_DREQ) || (state_q == S_RREQ) || (state_q == S_WRITE);
        mem_we     = (state_q == S_WRITE);
        mem_wdata  = (state_q == S_WRITE) ? mem_rdata : '0;
        case (state_q)
            S_DREQ:  mem_addr = {daddr_q + WADDR_W'(idx_q), 2'b00};
            S_RREQ:  mem_addr = {src_word, 2'b00};
            S_WRITE: mem_addr = {dst_word, 2'b00};
            default: mem_addr = '0;
        endcase
        walk_load  = (state_q == S_DCAP) && (idx_q == 2'd3);
        walk_step  = (state_q == S_WRITE);
        row_width  = mem_rdata[16+WIDTH_W-1:18];
        total      = mem_rdata[TOTAL_W-1:2];
        word_done  = (state_q == S_WRITE);
        node_done  = (state_q == S_NEXT);
        chain_done = (state_q == S_NEXT) && tag_q;
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> busy); // R3
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !busy && !mem_req); // R10
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we)); // R11
endmodule

// File: rtl/rect_chain_dma.sv
`timescale 1ns/1ps
// Top of the rectangular chained-descriptor DMA channel: register block,
// sequencer and rectangle walker. Assumes a memory that accepts one access
// per cycle and returns read data on the following cycle.
module rect_chain_dma
    import rcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic                 busy, word_done, node_done, chain_done;
    logic                 start_pulse, abort_pulse;
    logic [WADDR_W-1:0]   head_word, src_word, dst_word, src_base, dst_base;
    logic                 last_word, empty, walk_load, walk_step;
    logic [STRIDE_WW-1:0] src_stride, dst_stride;
    logic [WIDTH_WW-1:0]  row_width;
    logic [TOTAL_WW-1:0]  total;

    rcd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .word_done(word_done), .node_done(node_done), .chain_done(chain_done),
        .head_word(head_word), .start_pulse(start_pulse), .abort_pulse(abort_pulse)
    );

    rcd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
        .head_word(head_word), .mem_rdata(mem_rdata), .src_word(src_word),
        .dst_word(dst_word), .last_word(last_word), .empty(empty), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .walk_load(walk_load), .walk_step(walk_step), .src_base(src_base),
        .dst_base(dst_base), .src_stride(src_stride), .dst_stride(dst_stride),
        .row_width(row_width), .total(total), .word_done(word_done),
        .node_done(node_done), .chain_done(chain_done)
    );

    rcd_walk u_walk (
        .clk(clk), .rst_n(rst_n), .load(walk_load), .step(walk_step),
        .src_base(src_base), .dst_base(dst_base), .src_stride(src_stride),
        .dst_stride(dst_stride), .row_width(row_width), .total(total),
        .src_word(src_word), .dst_word(dst_word), .last_word(last_word), .empty(empty)
    );
endmodule

// File: tb/rect_chain_dma_bench.sv
`timescale 1ns/1ps
module rect_chain_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem     [0:4095];
    logic [31:0] ref_mem [0:4095];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rect_chain_dma u_rect_chain_dma (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Memory model: one access per cycle, read data one cycle later.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
        end
    end

    // R11 monitor: word-aligned addresses only.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_addr[1:0] != 2'b00) begin
            checks++; errors++;
            $display("FAIL R11 unaligned address actual=%h expected low bits 0", mem_addr);
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input bit sel, input logic [31:0] data);
        @(negedge clk);
        bus_sel = sel; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input bit sel, output logic [31:0] data);
        @(negedge clk);
        bus_sel = sel;
        #1 data = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 20000; i++) begin
            bus_read(1'b1, st);
            if (!st[0]) break;
        end
    endtask

    task automatic put_desc(input int byte_addr, input logic [31:0] src, input logic [31:0] dst,
                            input logic [13:0] sstr, input logic [13:0] dstr,
                            input logic [14:0] width, input logic [15:0] tot, input bit fin,
                            input logic [1:0] szt, input logic [1:0] pg);
        int a = (byte_addr >> 2) & 12'hFFF;
        mem[a]   = src;
        mem[a+1] = dst;
        mem[a+2] = {szt, sstr, pg, dstr};
        mem[a+3] = {fin, width, tot};
    endtask

    // Reference model of a whole chain on ref_mem, word by word.
    task automatic ref_run(input int head, output int bytes, output int nodes);
        int d = head & ~3;
        bytes = 0; nodes = 0;
        for (int n = 0; n < 256; n++) begin
            int a = (d >> 2) & 12'hFFF;
            logic [31:0] w0 = ref_mem[a], w1 = ref_mem[a+1], w2 = ref_mem[a+2], w3 = ref_mem[a+3];
            logic [29:0] srow = w0[31:2], drow = w1[31:2];
            logic [12:0] col = '0;
            int tot = w3[15:2];
            for (int k = 0; k < tot; k++) begin
                ref_mem[(drow + 30'(col)) & 12'hFFF] = ref_mem[(srow + 30'(col)) & 12'hFFF];
                bytes += 4;
                col = col + 13'd1;
                if (col == w3[30:18]) begin
                    col = '0;
                    srow = srow + 30'(w2[29:18]);
                    drow = drow + 30'(w2[13:2]);
                end
            end
            nodes++;
            if (w3[31]) break;
            d += 16;
        end
    endtask

    task automatic run_chain(input int head, input string req);
        int eb, en, mism;
        logic [31:0] st;
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
        ref_run(head, eb, en);
        bus_write(1'b0, head);
        bus_write(1'b1, 32'h1);
        wait_idle();
        bus_read(1'b1, st);
        check(st[2] == 1'b1 && st[0] == 1'b0, {req, " R8 end set, idle"}, st, 32'h4);
        check(st[31:16] == eb[15:0], {req, " R9 byte count"}, st[31:16], eb);
        check(st[15:8] == en[7:0], {req, " R9 node count"}, st[15:8], en);
        mism = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) mism++;
        check(mism == 0, {req, " R5 memory image"}, mism, 0);
    endtask

    initial begin
        logic [31:0] rd;
        int quiet;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(1'b0, rd); check(rd == 0, "R1 head after reset", rd, 0);
        bus_read(1'b1, rd); check(rd == 0, "R1 status after reset", rd, 0);
        check(mem_req == 1'b0, "R1 memory idle", mem_req, 0);

        // R2 head register masks low bits
        bus_write(1'b0, 32'h1234_5677);
        bus_read(1'b0, rd); check(rd == 32'h1234_5674, "R2 head readback", rd, 32'h1234_5674);

        // R4 R5 directed 2-D copy with ignored fields set
        put_desc(32'h100, 32'h800, 32'h2000, 14'd24, 14'd40, 15'd8, 16'd32, 1'b1, 2'b11, 2'b10);
        run_chain(32'h100, "R4 directed rect");

        // R6 total zero copies nothing
        put_desc(32'h100, 32'h900, 32'h2400, 14'd16, 14'd16, 15'd8, 16'd0, 1'b1, 2'b00, 2'b00);
        run_chain(32'h100, "R6 zero total");

        // R6 low bits of width/total/strides/addresses ignored
        put_desc(32'h100, 32'hA03, 32'h2601, 14'd27, 14'd33, 15'd10, 16'd35, 1'b1, 2'b01, 2'b01);
        run_chain(32'h102, "R6 low bits");

        // R5 width zero: single row, no stride advance
        put_desc(32'h100, 32'hB00, 32'h2800, 14'd400, 14'd400, 15'd0, 16'd64, 1'b1, 2'b00, 2'b00);
        run_chain(32'h100, "R5 width zero");

        // R7 directed chain of three
        put_desc(32'h140, 32'hC00, 32'h2A00, 14'd16, 14'd32, 15'd8,  16'd24, 1'b0, 2'b00, 2'b00);
        put_desc(32'h150, 32'hD00, 32'h2C00, 14'd4,  14'd8,  15'd4,  16'd16, 1'b0, 2'b10, 2'b11);
        put_desc(32'h160, 32'hE00, 32'h2E00, 14'd12, 14'd12, 15'd12, 16'd36, 1'b1, 2'b01, 2'b00);
        run_chain(32'h140, "R7 chain of three");

        // Random chains, R4 R5 R6 R7
        for (int t = 0; t < 8; t++) begin
            int nd = 1 + ($urandom % 3);
            for (int k = 0; k < nd; k++) begin
                int ww = 1 + ($urandom % 8);
                int rows = 1 + ($urandom % 6);
                int tw = ww * rows - ($urandom % ww);
                int ss = ww + ($urandom % 16);
                int ds = ww + ($urandom % 16);
                put_desc(32'h200 + 16 * k,
                         32'h400 + 4 * ($urandom % 1536), 32'h2000 + 4 * ($urandom % 1024),
                         14'(4 * ss), 14'(4 * ds), 15'(4 * ww), 16'(4 * tw),
                         (k == nd - 1), 2'($urandom), 2'($urandom));
            end
            run_chain(32'h200, "R7 random chain");
        end

        // R3 busy bit and start ignored while busy
        put_desc(32'h300, 32'h1000, 32'h3000, 14'd32, 14'd32, 15'd32, 16'd256, 1'b1, 2'b00, 2'b00);
        put_desc(32'h340, 32'h1400, 32'h3400, 14'd8,  14'd8,  15'd8,  16'd64,  1'b1, 2'b00, 2'b00);
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
        begin
            int eb, en, mism;
            ref_run(32'h300, eb, en);
            bus_write(1'b0, 32'h300);
            bus_write(1'b1, 32'h1);
            bus_read(1'b1, rd); check(rd[0] == 1'b1, "R3 busy while running", rd, 1);
            bus_write(1'b0, 32'h340);
            bus_write(1'b1, 32'h1);
            wait_idle();
            bus_read(1'b1, rd);
            check(rd[15:8] == 8'd1 && rd[31:16] == 16'd256, "R3 restart ignored counts", rd, 32'h0100_0104);
            mism = 0;
            for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) mism++;
            check(mism == 0, "R3 restart ignored memory", mism, 0);
        end

        // R10 reset mid transfer
        bus_write(1'b0, 32'h300);
        bus_write(1'b1, 32'h1);
        repeat (31) @(negedge clk);
        bus_sel = 1'b1; bus_wdata = 32'h2; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 rd = bus_rdata;
        check(rd == 32'h0, "R10 status after reset write", rd, 0);
        quiet = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1 if (mem_req) quiet++;
        end
        check(quiet == 0, "R10 memory silent after reset", quiet, 0);

        // R10 start and reset in one write
        bus_write(1'b1, 32'h3);
        #1 rd = bus_rdata;
        check(rd == 32'h0, "R10 reset wins over start", rd, 0);
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1 if (mem_req) quiet++;
        end
        check(quiet == 0, "R10 no start after combined write", quiet, 0);

        // R8 recovery: full chain after aborts, start clears previous state
        run_chain(32'h340, "R8 recovery run");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule